// File: doc/BRIEF.md
# Streaming Three-Channel INT8 Convolution Layer

This block is one convolution layer of an image-classification pipeline. It takes a raster stream of 8-bit signed pixels with three colour channels per pixel. It keeps the last few image rows on chip so that it can form a 5x5 window over all three channels at every pixel position. Once the window lies wholly inside the image, the block computes a configurable number of output feature maps (30 by default). Each map is the dot product of the 75 window samples with that map's own kernel, plus that map's bias. The sum is then scaled down by a programmable power of two, rectified, and clamped to the signed 8-bit range.

Kernels and biases sit in on-chip storage and are written through a simple write port before a frame is streamed. The same coefficients serve every window position. The maps are computed in tiles of `PE_N` parallel multiply-accumulate lanes, so a design can trade multipliers for cycles. The input is stalled with `in_ready` while a tile sequence runs. Results leave one per cycle in raster order, with the map index running fastest.

Top module: `conv_engine`

## Requirements
- R1: For a window whose bottom-right pixel is (x, y), map m computes bias[m] + sum of w[m][t]*p, where t = ch*25 + r*5 + c. Here p is channel ch of the pixel at (x-4+c, y-4+r), so r=0 is the oldest row and c=0 the leftmost column. Channel ch of a pixel is carried on `in_pix[8*ch+7:8*ch]`, and all samples and weights are signed 8-bit.
- R2: Every map uses its own kernel and its own 16-bit signed bias. Kernel word t of map m is written at `w_addr` = m*75 + t, and the bias of map m at `b_addr` = m.
- R3: A sum that is zero or negative produces an output of 0, so `out_data` is never negative.
- R4: A positive sum is arithmetically shifted right by `acc_shift` bits and then saturated to 127.
- R5: The stride is 1 and only windows that lie wholly inside the image produce output: (IMG_W-4)*(IMG_H-4) windows per frame. The position counters wrap at the end of a frame, so the next frame starts cleanly.
- R6: Outputs appear in raster order of the window position. For each position, maps 0 to MAPS-1 are emitted in ascending order, one per valid cycle, with `out_map` giving the index.
- R7: After reset `in_ready` is 1 and `out_valid` is 0. Accepting a pixel that completes a window drops `in_ready` until that position's last map is emitted, and other pixels are accepted without stall. Output is emitted only while `in_ready` is low. A final partial tile emits only the maps below MAPS.
- R8: Rewriting the coefficients of some maps between frames changes only those maps' results, and the other maps keep their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | 24 | Three signed 8-bit channels, channel 0 in the low byte |
| w_we | input | 1 | Kernel word write enable |
| w_addr | input | 12 | Kernel word address, map*75 + tap |
| w_data | input | 8 | Signed kernel word |
| b_we | input | 1 | Bias write enable |
| b_addr | input | 5 | Bias address (map index) |
| b_data | input | 16 | Signed bias |
| acc_shift | input | 5 | Layer exponent: right shift applied to the sum |
| out_valid | output | 1 | Result present |
| out_map | output | 5 | Output map index of the result |
| out_data | output | 8 | Rectified, scaled, saturated result |

## Verification
A stale row in the window history or a misplaced tap corrupts the first window of a frame. That shows at once as a wrong value on map 0 of the first output. A lane or tile counter that slips appears as a gap or repeat in `out_map` within the same output burst. It also appears as a result that belongs to a neighbouring map's kernel. The single-tap kernels in the rewrite frame pin the tap ordering to one pixel and one channel each, so any ordering error is visible on the very next window. The consecutive frames show a position counter that fails to wrap: the output count of the following frame changes.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int CH      = 3;
    localparam int K       = 5;
    localparam int TAPS    = CH * K * K;
    localparam int PIX_W   = 8;
    localparam int BIAS_W  = 16;
    localparam int ACC_W   = 24;
    localparam int SHIFT_W = 5;
    localparam int OUT_MAX = 127;

    typedef logic signed [PIX_W-1:0]  pix_t;
    typedef logic signed [BIAS_W-1:0] bias_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        pix_t  w;
        bias_t b;
    } coef_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_EMIT
    } phase_t;

    // Rectify, scale by 2^-sh and clamp to the positive int8 range.
    function automatic logic [PIX_W-1:0] requant(acc_t a, logic [SHIFT_W-1:0] sh);
        acc_t s;
        s = a >>> sh;
        if (a <= 0)
            return '0;
        if (s > acc_t'(OUT_MAX))
            return PIX_W'(OUT_MAX);
        return s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
#(
    parameter int IMG_W = 32,
    localparam int COL_W = $clog2(IMG_W)
) (
    input  logic                  clk,
    input  logic                  shift_en,
    input  logic [COL_W-1:0]      col,
    input  logic [CH*PIX_W-1:0]   pix,
    output pix_t                  win [TAPS]
);

    // Row history: entry 0 is the row just above the current one.
    logic [PIX_W-1:0] hist [CH][K-1][IMG_W];
    logic [PIX_W-1:0] grid [CH][K][K];

    always_ff @(posedge clk) begin
        if (shift_en) begin
            for (int ch = 0; ch < CH; ch++) begin
                hist[ch][0][col] <= pix[ch*PIX_W +: PIX_W];
                for (int k = 1; k < K-1; k++)
                    hist[ch][k][col] <= hist[ch][k-1][col];
                for (int r = 0; r < K; r++)
                    for (int c = 0; c < K-1; c++)
                        grid[ch][r][c] <= grid[ch][r][c+1];
                for (int r = 0; r < K-1; r++)
                    grid[ch][r][K-1] <= hist[ch][K-2-r][col];
                grid[ch][K-1][K-1] <= pix[ch*PIX_W +: PIX_W];
            end
        end
    end

    for (genvar ch = 0; ch < CH; ch++) begin : g_ch
        for (genvar r = 0; r < K; r++) begin : g_row
            for (genvar c = 0; c < K; c++) begin : g_col
                assign win[ch*K*K + r*K + c] = pix_t'(grid[ch][r][c]);
            end
        end
    end

endmodule

// File: rtl/conv_coef.sv
module conv_coef
    import conv_pkg::*;
#(
    parameter int MAPS = 30,
    parameter int PE_N = 6,
    localparam int AW = $clog2(MAPS*TAPS),
    localparam int MW = $clog2(MAPS),
    localparam int BW = $clog2(MAPS+PE_N),
    localparam int TW = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              w_we,
    input  logic [AW-1:0]     w_addr,
    input  logic [PIX_W-1:0]  w_data,
    input  logic              b_we,
    input  logic [MW-1:0]     b_addr,
    input  logic [BIAS_W-1:0] b_data,
    input  logic [BW-1:0]     base_map,
    input  logic [TW-1:0]     tap,
    output coef_t             rd [PE_N]
);

    logic [PIX_W-1:0]  wmem [MAPS*TAPS];
    logic [BIAS_W-1:0] bmem [MAPS];

    always_ff @(posedge clk) begin
        if (w_we)
            wmem[w_addr] <= w_data;
        if (b_we)
            bmem[b_addr] <= b_data;
    end

    for (genvar p = 0; p < PE_N; p++) begin : g_lane
        int lane_map;
        int lane_addr;
        assign lane_map  = int'(base_map) + p;
        assign lane_addr = lane_map * TAPS + int'(tap);
        assign rd[p] = (lane_map < MAPS)
                     ? {wmem[AW'(lane_addr)], bmem[MW'(lane_map)]}
                     : '0;
    end

endmodule

// File: rtl/conv_pe.sv
module conv_pe
    import conv_pkg::*;
(
    input  logic  clk,
    input  logic  en,
    input  logic  clr,
    input  coef_t cf,
    input  pix_t  x,
    output acc_t  acc
);

    logic signed [2*PIX_W-1:0] prod;

    assign prod = $signed(cf.w) * $signed(x);

    always_ff @(posedge clk) begin
        if (en)
            acc <= (clr ? acc_t'(cf.b) : acc) + acc_t'(prod);
    end

endmodule

// File: rtl/conv_engine.sv
module conv_engine
    import conv_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int MAPS  = 30,
    parameter int PE_N  = 6,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H),
    localparam int MAP_W = $clog2(MAPS),
    localparam int AW    = $clog2(MAPS*TAPS),
    localparam int BW    = $clog2(MAPS+PE_N),
    localparam int TW    = $clog2(TAPS),
    localparam int IW    = (PE_N > 1) ? $clog2(PE_N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CH*PIX_W-1:0] in_pix,
    input  logic                w_we,
    input  logic [AW-1:0]       w_addr,
    input  logic [PIX_W-1:0]    w_data,
    input  logic                b_we,
    input  logic [MAP_W-1:0]    b_addr,
    input  logic [BIAS_W-1:0]   b_data,
    input  logic [SHIFT_W-1:0]  acc_shift,
    output logic                out_valid,
    output logic [MAP_W-1:0]    out_map,
    output logic [PIX_W-1:0]    out_data
);

    phase_t           phase;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [TW-1:0]    tap;
    logic [BW-1:0]    base;
    logic [IW-1:0]    idx;
    logic [BW-1:0]    cur_map;
    logic             accept;
    logic             win_ok;
    logic             last_lane;
    logic             last_map;

    pix_t  win [TAPS];
    coef_t rd  [PE_N];
    acc_t  acc [PE_N];

    assign in_ready  = (phase == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign win_ok    = (col >= COL_W'(K-1)) && (row >= ROW_W'(K-1));
    assign cur_map   = base + BW'(idx);
    assign last_lane = (idx == IW'(PE_N-1));
    assign last_map  = (cur_map == BW'(MAPS-1));

    conv_window #(.IMG_W(IMG_W)) u_window (
        .clk      (clk),
        .shift_en (accept),
        .col      (col),
        .pix      (in_pix),
        .win      (win)
    );

    conv_coef #(.MAPS(MAPS), .PE_N(PE_N)) u_coef (
        .clk      (clk),
        .w_we     (w_we),
        .w_addr   (w_addr),
        .w_data   (w_data),
        .b_we     (b_we),
        .b_addr   (b_addr),
        .b_data   (b_data),
        .base_map (base),
        .tap      (tap),
        .rd       (rd)
    );

    for (genvar p = 0; p < PE_N; p++) begin : g_pe
        conv_pe u_pe (
            .clk (clk),
            .en  (phase == ST_MAC),
            .clr (tap == '0),
            .cf  (rd[p]),
            .x   (win[tap]),
            .acc (acc[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            col   <= '0;
            row   <= '0;
            tap   <= '0;
            base  <= '0;
            idx   <= '0;
        end else begin
            unique case (phase)
                ST_IDLE: begin
                    if (accept) begin
                        if (col == COL_W'(IMG_W-1)) begin
                            col <= '0;
                            row <= (row == ROW_W'(IMG_H-1)) ? '0 : row + 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                        if (win_ok) begin
                            phase <= ST_MAC;
                            tap   <= '0;
                            base  <= '0;
                        end
                    end
                end
                ST_MAC: begin
                    if (tap == TW'(TAPS-1)) begin
                        phase <= ST_EMIT;
                        idx   <= '0;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (last_map) begin
                        phase <= ST_IDLE;
                    end else if (last_lane) begin
                        base  <= base + BW'(PE_N);
                        tap   <= '0;
                        phase <= ST_MAC;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (phase == ST_EMIT);
    assign out_map   = cur_map[MAP_W-1:0];
    assign out_data  = requant(acc[idx], acc_shift);

endmodule

// File: rtl/conv_checker.sv
module conv_checker #(
    parameter int MAPS  = 30,
    parameter int MAP_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [MAP_W-1:0] out_map,
    input logic [7:0]       out_data
);

    logic [MAP_W-1:0] prev_map;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_map <= '0;
            seen     <= 1'b0;
        end else if (out_valid) begin
            prev_map <= out_map;
            seen     <= 1'b1;
        end
    end

    p_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_data[7]);

    p_map_range_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_map) < MAPS));

    p_map_step_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_map != '0) |-> (seen && out_map == MAP_W'(prev_map + 1'b1)));

    p_map_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_map == '0) |-> (!seen || int'(prev_map) == MAPS-1));

    p_stall_out_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid));

endmodule

bind conv_engine conv_checker #(.MAPS(MAPS), .MAP_W(MAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_map   (out_map),
    .out_data  (out_data)
);

// File: tb/conv_engine_tb_top.sv
module conv_engine_tb_top;

    localparam int IMG_W = 8;
    localparam int IMG_H = 7;
    localparam int MAPS  = 30;
    localparam int PE_N  = 7;
    localparam int TAPS  = 75;
    localparam int AW    = $clog2(MAPS*TAPS);
    localparam int MAP_W = $clog2(MAPS);
    localparam int WINS  = (IMG_W-4)*(IMG_H-4);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [23:0]      in_pix = '0;
    logic             w_we = 1'b0;
    logic [AW-1:0]    w_addr = '0;
    logic [7:0]       w_data = '0;
    logic             b_we = 1'b0;
    logic [MAP_W-1:0] b_addr = '0;
    logic [15:0]      b_data = '0;
    logic [4:0]       acc_shift = '0;
    logic             out_valid;
    logic [MAP_W-1:0] out_map;
    logic [7:0]       out_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int out_cnt = 0;
    string cur_req = "R1";

    int wm [MAPS][TAPS];
    int bm [MAPS];
    int img [3][IMG_H][IMG_W];
    int shift_val = 0;
    int unsigned seed = 32'h1234_5678;
    int exp_map_q [$];
    int exp_val_q [$];

    always #5 clk = ~clk;

    conv_engine #(.IMG_W(IMG_W), .IMG_H(IMG_H), .MAPS(MAPS), .PE_N(PE_N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .w_we      (w_we),
        .w_addr    (w_addr),
        .w_data    (w_data),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .b_data    (b_data),
        .acc_shift (acc_shift),
        .out_valid (out_valid),
        .out_map   (out_map),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[23:16]) - 128;
    endfunction

    function automatic int ref_out(int m, int x, int y);
        int s;
        s = bm[m];
        for (int ch = 0; ch < 3; ch++)
            for (int r = 0; r < 5; r++)
                for (int c = 0; c < 5; c++)
                    s += wm[m][ch*25 + r*5 + c] * img[ch][y-4+r][x-4+c];
        if (s <= 0)
            return 0;
        s = s >>> shift_val;
        return (s > 127) ? 127 : s;
    endfunction

    // Reference model: compare every output beat against the queue.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            out_cnt++;
            if (exp_map_q.size() == 0) begin
                chk(1'b0, "R6", int'(out_map), -1);
            end else begin
                automatic int em = exp_map_q.pop_front();
                automatic int ev = exp_val_q.pop_front();
                chk(int'(out_map) == em, "R6", int'(out_map), em);
                chk(int'(out_data) == ev, cur_req, int'(out_data), ev);
            end
        end
    end

    task automatic write_maps(input int lo, input int hi);
        for (int m = lo; m <= hi; m++) begin
            for (int t = 0; t < TAPS; t++) begin
                @(negedge clk);
                w_we   = 1'b1;
                w_addr = AW'(m*TAPS + t);
                w_data = 8'(wm[m][t]);
            end
            @(negedge clk);
            w_we   = 1'b0;
            b_we   = 1'b1;
            b_addr = MAP_W'(m);
            b_data = 16'(bm[m]);
        end
        @(negedge clk);
        w_we = 1'b0;
        b_we = 1'b0;
    endtask

    // mode 0: random, 1: all 127
    task automatic make_image(input int mode);
        for (int ch = 0; ch < 3; ch++)
            for (int y = 0; y < IMG_H; y++)
                for (int x = 0; x < IMG_W; x++)
                    img[ch][y][x] = (mode == 1) ? 127 : rnd8();
    endtask

    task automatic run_frame(input string req);
        int guard;
        cur_req = req;
        acc_shift = 5'(shift_val);
        out_cnt = 0;
        for (int y = 4; y < IMG_H; y++)
            for (int x = 4; x < IMG_W; x++)
                for (int m = 0; m < MAPS; m++) begin
                    exp_map_q.push_back(m);
                    exp_val_q.push_back(ref_out(m, x, y));
                end
        for (int y = 0; y < IMG_H; y++) begin
            for (int x = 0; x < IMG_W; x++) begin
                in_valid = 1'b1;
                in_pix = {8'(img[2][y][x]), 8'(img[1][y][x]), 8'(img[0][y][x])};
                while (in_ready !== 1'b1) @(negedge clk);
                @(negedge clk);
                in_valid = 1'b0;
                // R7: stall only after a pixel that completes a window
                chk(in_ready == !(x >= 4 && y >= 4), "R7", int'(in_ready),
                    int'(!(x >= 4 && y >= 4)));
            end
        end
        guard = 0;
        while (exp_map_q.size() > 0 && guard < 50000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        // R5: one result per map for each fully valid window
        chk(out_cnt == WINS*MAPS, "R5", out_cnt, WINS*MAPS);
        chk(exp_map_q.size() == 0, "R5", exp_map_q.size(), 0);
        exp_map_q.delete();
        exp_val_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R7", int'(out_valid), 0);

        // R1 / R2: random kernels and biases, random image
        for (int m = 0; m < MAPS; m++) begin
            for (int t = 0; t < TAPS; t++) wm[m][t] = rnd8();
            bm[m] = rnd8() * 16;
        end
        write_maps(0, MAPS-1);
        shift_val = 10;
        make_image(0);
        run_frame("R1");
        // R5: second frame with same coefficients checks counter wrap
        make_image(0);
        run_frame("R5");

        // R3 / R2: zero kernels, per-map bias with alternating sign
        for (int m = 0; m < MAPS; m++) begin
            for (int t = 0; t < TAPS; t++) wm[m][t] = 0;
            bm[m] = (m % 2 == 1) ? -(m*100) : m*40;
        end
        write_maps(0, MAPS-1);
        shift_val = 2;
        make_image(0);
        run_frame("R3");

        // R4: saturation and large shift
        for (int m = 0; m < MAPS; m++) begin
            for (int t = 0; t < TAPS; t++) wm[m][t] = 127;
            bm[m] = 0;
        end
        write_maps(0, MAPS-1);
        shift_val = 0;
        make_image(1);
        run_frame("R4");
        shift_val = 20;
        run_frame("R4");

        // R8 / R1: rewrite maps 0, 1 and 29 only with single-tap kernels
        for (int m = 0; m < MAPS; m++) begin
            if (m == 0 || m == 1 || m == 29) begin
                for (int t = 0; t < TAPS; t++) wm[m][t] = 0;
                bm[m] = 0;
            end
        end
        wm[0][12]  = 1;   // channel 0, centre
        wm[1][50]  = 1;   // channel 2, oldest row, leftmost column
        wm[29][37] = 1;   // channel 1, centre
        write_maps(0, 1);
        write_maps(29, 29);
        shift_val = 0;
        make_image(0);
        run_frame("R8");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule